// File: doc/BRIEF.md
# Parallel Panel Write Sequencer

This block feeds a display panel that sits on an 8080-style parallel CPU bus. Once a frame is triggered, it takes pixels from a valid/ready stream and produces one write cycle per pixel: it holds chip select low for the whole frame and pulses the write strobe low while it drives the pixel on the data bus. The chip-select setup time, the write setup, active and hold phases are each counted in clock cycles and programmed through a small register write port.

A frame starts from one of two sources. Software can write a command bit. A hardware tearing-effect (TE) input can start a frame on its rising edge, which lets the panel pace the frames. A busy guard drops any trigger that arrives while a frame is still running, because a repeated start can upset the panel. When the last pixel's hold phase ends, the block releases chip select and emits a one-cycle frame-done pulse. That pulse also sets a sticky status bit, which drives an interrupt output when the interrupt is enabled.

Top module: `i80_write_seq`

## Requirements
- R1: After reset, chip select and write strobe are high (inactive), and pix_ready_o, frame_done_o, busy_o and irq_o are low.
- R2: Writing word address 0 sets the phase counts: chip-select setup in bits [19:16], write setup in [15:12], write-active width in [11:8] and write hold in [7:4]. Chip-select setup cycles elapse once before the first pixel. Each pixel then takes one fetch cycle, the write-setup cycles, the active cycles and the hold cycles, with chip select low throughout. A count of zero skips its phase.
- R3: The write strobe stays low for exactly max(active, 1) cycles per pixel, and only while chip select is low.
- R4: Chip select stays low from the start of a frame until the last pixel's hold phase has ended. It rises in the same cycle that frame_done_o is high.
- R5: A frame carries width × height pixels. Word address 2 holds the width in bits [11:0] and the height in bits [27:16]. Pixels go out in stream order, each driven on lcd_data_o while the strobe is low. A zero-sized frame gives only the done pulse and never asserts chip select.
- R6: frame_done_o is a one-cycle pulse. It sets a sticky status bit whether or not the interrupt is enabled. irq_o is that status bit ANDed with the enable, which is bit 0 at word address 3. Writing 1 to bit 0 at word address 4 clears the status.
- R7: A write to word address 1 with bit 0 (software trigger mode) and bit 1 (command) both set starts a frame. The command bit is not retained, and a command written without the mode bit does nothing.
- R8: A rising edge on te_i starts a frame when bit 3 (TE enable) at word address 1 is set and bit 4 (TE mask) is clear. Otherwise te_i has no effect.
- R9: Any trigger that arrives while a frame is in progress is dropped. Only the frame in progress is sent, and no second frame follows it.
- R10: busy_o rises on an accepted trigger. With the interrupt enabled, it stays high until the frame-done pulse. With the interrupt disabled, it falls one cycle after the trigger is accepted.
- R11: Bit 0 at word address 0 enables the interface. While it is clear, all triggers are ignored.
- R12: The phase counts are captured when a frame starts. Writing new phase counts during a frame does not change that frame's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register word address |
| cfg_wdata_i | input | 32 | Register write data |
| te_i | input | 1 | Tearing-effect input from the panel |
| pix_valid_i | input | 1 | Pixel stream valid |
| pix_data_i | input | DATA_W | Pixel stream data |
| pix_ready_o | output | 1 | Pixel stream ready |
| lcd_cs_n_o | output | 1 | Panel chip select, active low |
| lcd_wr_n_o | output | 1 | Panel write strobe, active low |
| lcd_data_o | output | DATA_W | Panel data bus |
| busy_o | output | 1 | Trigger guard state |
| frame_done_o | output | 1 | One-cycle frame-done pulse |
| irq_o | output | 1 | Frame-done interrupt (status AND enable) |

## Verification
The hardest case to reach is a second trigger, from either source, landing while a frame is in progress. This matters most with the interrupt disabled, because then the busy flag has already fallen and only the engine's own idle check protects the frame. The stimulus picks a random cycle inside the frame window, computed from the programmed phase counts, and injects a software command or a TE edge there. At other random cycles it instead rewrites the phase counts. It then checks that the pulse count, the pulse widths and the chip-select length still match the original frame, and that chip select stays high after the frame ends.

// File: rtl/i80_seq_pkg.sv
package i80_seq_pkg;

    localparam int PH_W = 4;

    localparam logic [2:0] A_TIMING = 3'd0;
    localparam logic [2:0] A_TRIG   = 3'd1;
    localparam logic [2:0] A_SIZE   = 3'd2;
    localparam logic [2:0] A_IRQEN  = 3'd3;
    localparam logic [2:0] A_IRQCLR = 3'd4;

    typedef struct packed {
        logic [PH_W-1:0] cs_setup;
        logic [PH_W-1:0] wr_setup;
        logic [PH_W-1:0] wr_active;
        logic [PH_W-1:0] wr_hold;
    } phase_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CSU,
        ST_FETCH,
        ST_WSU,
        ST_ACT,
        ST_HLD
    } eng_state_e;

endpackage

// File: rtl/i80_trig_ctrl.sv
module i80_trig_ctrl
    import i80_seq_pkg::*;
#(
    parameter int DIM_W  = 12,
    localparam int NPIX_W = 2 * DIM_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cfg_we_i,
    input  logic [2:0]        cfg_addr_i,
    input  logic [31:0]       cfg_wdata_i,
    input  logic              te_i,
    input  logic              eng_idle_i,
    input  logic              done_i,
    output logic              start_o,
    output phase_t            timing_o,
    output logic [NPIX_W-1:0] npix_o,
    output logic              busy_o,
    output logic              irq_o
);

    typedef struct packed {
        phase_t             tim;
        logic               en;
        logic               sw_mode;
        logic               te_en;
        logic               te_mask;
        logic [DIM_W-1:0]   width;
        logic [DIM_W-1:0]   height;
        logic               irq_en;
        logic               irq_stat;
        logic               busy;
        logic               te_q;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  sw_req, hw_req, start;

    always_comb begin
        ctrl_d = ctrl_q;
        sw_req = cfg_we_i && (cfg_addr_i == A_TRIG) && cfg_wdata_i[1] && cfg_wdata_i[0];
        hw_req = te_i && !ctrl_q.te_q && ctrl_q.te_en && !ctrl_q.te_mask;
        start  = (sw_req || hw_req) && ctrl_q.en && !ctrl_q.busy && eng_idle_i;

        ctrl_d.te_q = te_i;

        if (cfg_we_i) begin
            case (cfg_addr_i)
                A_TIMING: begin
                    ctrl_d.tim.cs_setup  = cfg_wdata_i[19:16];
                    ctrl_d.tim.wr_setup  = cfg_wdata_i[15:12];
                    ctrl_d.tim.wr_active = cfg_wdata_i[11:8];
                    ctrl_d.tim.wr_hold   = cfg_wdata_i[7:4];
                    ctrl_d.en            = cfg_wdata_i[0];
                end
                A_TRIG: begin
                    ctrl_d.sw_mode = cfg_wdata_i[0];
                    ctrl_d.te_en   = cfg_wdata_i[3];
                    ctrl_d.te_mask = cfg_wdata_i[4];
                end
                A_SIZE: begin
                    ctrl_d.width  = cfg_wdata_i[DIM_W-1:0];
                    ctrl_d.height = cfg_wdata_i[16+DIM_W-1:16];
                end
                A_IRQEN:  ctrl_d.irq_en = cfg_wdata_i[0];
                A_IRQCLR: if (cfg_wdata_i[0]) ctrl_d.irq_stat = 1'b0;
                default: ;
            endcase
        end

        if (done_i) ctrl_d.irq_stat = 1'b1;

        if (start) begin
            ctrl_d.busy = 1'b1;
        end else if (ctrl_q.busy && (!ctrl_q.irq_en || done_i)) begin
            ctrl_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ctrl_q               <= '0;
            ctrl_q.tim.wr_active <= PH_W'(1);
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign start_o  = start;
    assign timing_o = ctrl_q.tim;
    assign npix_o   = {{DIM_W{1'b0}}, ctrl_q.width} * {{DIM_W{1'b0}}, ctrl_q.height};
    assign busy_o   = ctrl_q.busy;
    assign irq_o    = ctrl_q.irq_stat && ctrl_q.irq_en;

    // R10
    busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_q.busy && ctrl_q.irq_en && !done_i && !(cfg_we_i && cfg_addr_i == A_IRQEN))
        |=> ctrl_q.busy);

    // R6
    stat_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_we_i && cfg_addr_i == A_IRQCLR && cfg_wdata_i[0] && !done_i)
        |=> !ctrl_q.irq_stat);

endmodule

// File: rtl/i80_cycle_engine.sv
module i80_cycle_engine
    import i80_seq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int NPIX_W = 24
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  phase_t            timing_i,
    input  logic [NPIX_W-1:0] npix_i,
    input  logic              pix_valid_i,
    input  logic [DATA_W-1:0] pix_data_i,
    output logic              pix_ready_o,
    output logic              cs_n_o,
    output logic              wr_n_o,
    output logic [DATA_W-1:0] data_o,
    output logic              idle_o,
    output logic              done_o
);

    typedef struct packed {
        eng_state_e        state;
        logic [PH_W-1:0]   cnt;
        logic [NPIX_W-1:0] left;
        phase_t            tim;
        logic [DATA_W-1:0] data;
        logic              done;
    } eng_t;

    eng_t            eng_d, eng_q;
    logic            pix_end;
    logic [PH_W-1:0] act_m1;

    always_comb begin
        eng_d       = eng_q;
        eng_d.done  = 1'b0;
        pix_end     = 1'b0;
        pix_ready_o = 1'b0;
        act_m1      = (eng_q.tim.wr_active == '0) ? '0 : eng_q.tim.wr_active - 1'b1;

        case (eng_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    eng_d.tim = timing_i;
                    if (npix_i == '0) begin
                        eng_d.done = 1'b1;
                    end else begin
                        eng_d.left = npix_i;
                        if (timing_i.cs_setup != '0) begin
                            eng_d.state = ST_CSU;
                            eng_d.cnt   = timing_i.cs_setup - 1'b1;
                        end else begin
                            eng_d.state = ST_FETCH;
                        end
                    end
                end
            end
            ST_CSU: begin
                if (eng_q.cnt == '0) eng_d.state = ST_FETCH;
                else                 eng_d.cnt   = eng_q.cnt - 1'b1;
            end
            ST_FETCH: begin
                pix_ready_o = pix_valid_i;
                if (pix_valid_i) begin
                    eng_d.data = pix_data_i;
                    if (eng_q.tim.wr_setup != '0) begin
                        eng_d.state = ST_WSU;
                        eng_d.cnt   = eng_q.tim.wr_setup - 1'b1;
                    end else begin
                        eng_d.state = ST_ACT;
                        eng_d.cnt   = act_m1;
                    end
                end
            end
            ST_WSU: begin
                if (eng_q.cnt == '0) begin
                    eng_d.state = ST_ACT;
                    eng_d.cnt   = act_m1;
                end else begin
                    eng_d.cnt = eng_q.cnt - 1'b1;
                end
            end
            ST_ACT: begin
                if (eng_q.cnt == '0) begin
                    if (eng_q.tim.wr_hold != '0) begin
                        eng_d.state = ST_HLD;
                        eng_d.cnt   = eng_q.tim.wr_hold - 1'b1;
                    end else begin
                        pix_end = 1'b1;
                    end
                end else begin
                    eng_d.cnt = eng_q.cnt - 1'b1;
                end
            end
            ST_HLD: begin
                if (eng_q.cnt == '0) pix_end   = 1'b1;
                else                 eng_d.cnt = eng_q.cnt - 1'b1;
            end
            default: eng_d.state = ST_IDLE;
        endcase

        if (pix_end) begin
            eng_d.left = eng_q.left - 1'b1;
            if (eng_q.left == NPIX_W'(1)) begin
                eng_d.state = ST_IDLE;
                eng_d.done  = 1'b1;
            end else begin
                eng_d.state = ST_FETCH;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            eng_q       <= '0;
            eng_q.state <= ST_IDLE;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign cs_n_o = (eng_q.state == ST_IDLE);
    assign wr_n_o = (eng_q.state != ST_ACT);
    assign data_o = eng_q.data;
    assign idle_o = (eng_q.state == ST_IDLE);
    assign done_o = eng_q.done;

    // R3
    wr_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_n_o |-> !cs_n_o);

    // R6
    done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R4
    cs_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(cs_n_o) |-> done_o);

    // R5
    ready_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pix_ready_o |-> (!cs_n_o && wr_n_o));

endmodule

// File: rtl/i80_write_seq.sv
module i80_write_seq
    import i80_seq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DIM_W  = 12
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cfg_we_i,
    input  logic [2:0]        cfg_addr_i,
    input  logic [31:0]       cfg_wdata_i,
    input  logic              te_i,
    input  logic              pix_valid_i,
    input  logic [DATA_W-1:0] pix_data_i,
    output logic              pix_ready_o,
    output logic              lcd_cs_n_o,
    output logic              lcd_wr_n_o,
    output logic [DATA_W-1:0] lcd_data_o,
    output logic              busy_o,
    output logic              frame_done_o,
    output logic              irq_o
);

    localparam int NPIX_W = 2 * DIM_W;

    logic              start;
    logic              eng_idle;
    logic              done;
    phase_t            timing;
    logic [NPIX_W-1:0] npix;

    i80_trig_ctrl #(.DIM_W(DIM_W)) ctrl_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cfg_we_i    (cfg_we_i),
        .cfg_addr_i  (cfg_addr_i),
        .cfg_wdata_i (cfg_wdata_i),
        .te_i        (te_i),
        .eng_idle_i  (eng_idle),
        .done_i      (done),
        .start_o     (start),
        .timing_o    (timing),
        .npix_o      (npix),
        .busy_o      (busy_o),
        .irq_o       (irq_o)
    );

    i80_cycle_engine #(.DATA_W(DATA_W), .NPIX_W(NPIX_W)) eng_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .start_i     (start),
        .timing_i    (timing),
        .npix_i      (npix),
        .pix_valid_i (pix_valid_i),
        .pix_data_i  (pix_data_i),
        .pix_ready_o (pix_ready_o),
        .cs_n_o      (lcd_cs_n_o),
        .wr_n_o      (lcd_wr_n_o),
        .data_o      (lcd_data_o),
        .idle_o      (eng_idle),
        .done_o      (done)
    );

    assign frame_done_o = done;

endmodule

// File: tb/i80_write_seq_tb.sv
module i80_write_seq_tb_top;

    localparam int DATA_W = 16;
    localparam int LIMIT  = 4000;

    logic              clk_i = 1'b0;
    logic              rst_ni = 1'b0;
    logic              cfg_we_i = 1'b0;
    logic [2:0]        cfg_addr_i = '0;
    logic [31:0]       cfg_wdata_i = '0;
    logic              te_i = 1'b0;
    logic              pix_valid_i = 1'b1;
    logic [DATA_W-1:0] pix_data_i = '0;
    logic              pix_ready_o, lcd_cs_n_o, lcd_wr_n_o, busy_o, frame_done_o, irq_o;
    logic [DATA_W-1:0] lcd_data_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #4 clk_i = ~clk_i;

    i80_write_seq dut_i (
        .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i, .te_i,
        .pix_valid_i, .pix_data_i, .pix_ready_o, .lcd_cs_n_o, .lcd_wr_n_o,
        .lcd_data_o, .busy_o, .frame_done_o, .irq_o
    );

    task automatic chk(bit ok, string req, int act, int exp, string what);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] tim_word(int cs, int ws, int ac, int ho, bit en);
        return (cs << 16) | (ws << 12) | (ac << 8) | (ho << 4) | 32'(en);
    endfunction

    function automatic int frame_cycles(int cs, int ws, int ac, int ho, int n);
        int ae = (ac == 0) ? 1 : ac;
        if (n == 0) return 0;
        return cs + n * (1 + ws + ae + ho);
    endfunction

    task automatic wr_reg(logic [2:0] a, logic [31:0] d);
        @(negedge clk_i);
        cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
        @(posedge clk_i);
        #1;
        cfg_we_i = 1'b0;
    endtask

    task automatic expect_quiet(int cycles, string req, string what);
        int bad = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk_i); #1;
            if (!lcd_cs_n_o || frame_done_o || busy_o) bad++;
        end
        chk(bad == 0, req, bad, 0, what);
    endtask

    task automatic te_pulse();
        @(negedge clk_i); te_i = 1'b1;
        @(posedge clk_i); #1;
        @(negedge clk_i); te_i = 1'b0;
    endtask

    // inj: 0 none, 1 software command, 2 TE edge, 3 new phase counts
    task automatic do_frame(int cs, int ws, int ac, int ho, int w, int h, bit use_te,
                            bit irqen, int inj, bit stall);
        int n = w * h;
        int ae = (ac == 0) ? 1 : ac;
        int exp_total = frame_cycles(cs, ws, ac, ho, n);
        int inj_cyc = 0;
        int c = 0, cs_low = 0, pulses = 0, wrlen = 0, bad_w = 0, data_err = 0;
        int lead = -1, tail = 0, done_cnt = 0, busy_bad = 0, extra = 0;
        int busy1 = 0, busy2 = 0;
        bit done_seen = 0, rel_ok = 0, pend = 0;
        logic [DATA_W-1:0] base = DATA_W'($urandom);

        if (inj != 0 && exp_total >= 3) inj_cyc = 2 + int'($urandom % (exp_total - 2));
        wr_reg(3'd4, 32'd1);
        wr_reg(3'd3, 32'(irqen));
        wr_reg(3'd2, (h << 16) | w);
        wr_reg(3'd0, tim_word(cs, ws, ac, ho, 1'b1));
        pix_data_i = base;
        pix_valid_i = 1'b1;
        if (use_te) begin
            wr_reg(3'd1, 32'h8);
            @(negedge clk_i); te_i = 1'b1;
            @(posedge clk_i); #1;
        end else begin
            wr_reg(3'd1, 32'h3);
        end

        while (!done_seen && c < LIMIT) begin
            @(negedge clk_i);
            c++;
            te_i = 1'b0;
            cfg_we_i = 1'b0;
            if (pend) begin pix_data_i = pix_data_i + 1'b1; pend = 0; end
            if (stall) pix_valid_i = ($urandom % 3) != 0;
            if (c == inj_cyc) begin
                case (inj)
                    1: begin cfg_we_i = 1'b1; cfg_addr_i = 3'd1; cfg_wdata_i = use_te ? 32'hB : 32'h3; end
                    2: te_i = 1'b1;
                    3: begin cfg_we_i = 1'b1; cfg_addr_i = 3'd0;
                             cfg_wdata_i = tim_word(($urandom % 16), ($urandom % 16),
                                                    ($urandom % 16), ($urandom % 16), 1'b1); end
                    default: ;
                endcase
            end
            #1;
            if (c == 1) busy1 = busy_o;
            if (c == 2) busy2 = busy_o;
            if (!lcd_cs_n_o) begin
                cs_low++;
                if (irqen && !busy_o) busy_bad++;
            end
            if (!lcd_wr_n_o) begin
                if (wrlen == 0 && pulses == 0) lead = cs_low - 1;
                if (lcd_data_o != DATA_W'(base + DATA_W'(pulses))) data_err++;
                wrlen++;
            end else if (wrlen > 0) begin
                if (wrlen != ae) bad_w++;
                pulses++;
                wrlen = 0;
            end
            if (!lcd_cs_n_o && lcd_wr_n_o && pulses == n) tail++;
            if (pix_ready_o) pend = 1;
            if (frame_done_o) begin
                done_cnt++;
                done_seen = 1;
                rel_ok = lcd_cs_n_o;
            end
        end
        cfg_we_i = 1'b0;
        te_i = 1'b0;
        pix_valid_i = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk_i); #1;
            if (!lcd_cs_n_o || frame_done_o) extra++;
        end

        chk(c < LIMIT, "R4", c, LIMIT, "frame finished before timeout");
        chk(pulses == n, "R5", pulses, n, "write pulses per frame");
        chk(data_err == 0, "R5", data_err, 0, "pixel order on data bus");
        chk(bad_w == 0, "R3", bad_w, 0, "strobe width errors");
        chk(done_cnt == 1, "R6", done_cnt, 1, "done pulse count");
        chk(rel_ok, "R4", rel_ok, 1, "chip select high with done");
        if (inj != 0) chk(extra == 0, "R9", extra, 0, "activity after frame");
        else          chk(extra == 0, "R6", extra, 0, "activity after frame");
        if (!stall) begin
            if (inj == 3) chk(cs_low == exp_total, "R12", cs_low, exp_total, "frame length after mid-frame rewrite");
            else          chk(cs_low == exp_total, "R2", cs_low, exp_total, "chip select low cycles");
            if (n > 0) begin
                chk(lead == cs + 1 + ws, "R2", lead, cs + 1 + ws, "cycles before first strobe");
                chk(tail == ho, "R4", tail, ho, "hold cycles before release");
            end
        end
        if (n > 0) begin
            if (irqen) chk(busy_bad == 0, "R10", busy_bad, 0, "busy low during frame");
            else begin
                chk(busy1 == 1 && busy2 == 0, "R10", busy1 * 10 + busy2, 10, "busy without irq");
            end
        end
        chk(irq_o == irqen, "R6", irq_o, irqen, "irq after frame");
        if (irqen) begin
            wr_reg(3'd4, 32'd1);
            @(negedge clk_i); #1;
            chk(irq_o == 1'b0, "R6", irq_o, 0, "irq after write-one-clear");
        end
    endtask

    initial begin
        while (1) begin
            @(posedge clk_i);
            cyc++;
            if (cyc > 190000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected below 190000", cyc);
                $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h1A2B3C4D));
        repeat (3) @(negedge clk_i);
        #1;
        chk(lcd_cs_n_o && lcd_wr_n_o, "R1", {lcd_cs_n_o, lcd_wr_n_o}, 3, "bus idle in reset");
        rst_ni = 1'b1;
        @(negedge clk_i); #1;
        chk(!pix_ready_o && !frame_done_o && !busy_o && !irq_o, "R1",
            {pix_ready_o, frame_done_o, busy_o, irq_o}, 0, "control outputs after reset");
        chk(lcd_cs_n_o && lcd_wr_n_o, "R1", {lcd_cs_n_o, lcd_wr_n_o}, 3, "bus idle after reset");

        // R11: disabled interface ignores triggers
        wr_reg(3'd0, tim_word(1, 1, 1, 1, 1'b0));
        wr_reg(3'd2, (1 << 16) | 1);
        wr_reg(3'd1, 32'h3);
        expect_quiet(8, "R11", "software trigger while disabled");
        wr_reg(3'd1, 32'h8);
        te_pulse();
        expect_quiet(8, "R11", "TE trigger while disabled");

        // R7 / R8: triggers without their enables
        wr_reg(3'd0, tim_word(1, 1, 1, 1, 1'b1));
        wr_reg(3'd1, 32'h2);
        expect_quiet(8, "R7", "command without mode bit");
        wr_reg(3'd1, 32'h18);
        te_pulse();
        expect_quiet(8, "R8", "masked TE");
        wr_reg(3'd1, 32'h0);
        te_pulse();
        expect_quiet(8, "R8", "TE not enabled");

        // directed frames
        do_frame(0, 0, 0, 0, 3, 1, 1'b0, 1'b1, 0, 1'b0);   // R3 zero active
        do_frame(15, 15, 15, 15, 2, 2, 1'b0, 1'b1, 0, 1'b0);
        do_frame(2, 1, 3, 2, 2, 3, 1'b1, 1'b0, 0, 1'b0);   // R8 TE start
        do_frame(3, 2, 2, 1, 0, 4, 1'b0, 1'b1, 0, 1'b0);   // R5 zero size
        do_frame(1, 0, 2, 0, 4, 2, 1'b0, 1'b0, 0, 1'b1);   // R5 stalls

        // R7: command bit not retained
        wr_reg(3'd1, 32'h1);
        expect_quiet(8, "R7", "mode bit alone after a frame");

        // R6: status set while irq disabled
        do_frame(0, 1, 1, 1, 1, 1, 1'b0, 1'b0, 0, 1'b0);
        wr_reg(3'd3, 32'd1);
        @(negedge clk_i); #1;
        chk(irq_o == 1'b1, "R6", irq_o, 1, "status kept while irq disabled");

        // R9 / R12 directed
        do_frame(2, 2, 2, 2, 3, 2, 1'b0, 1'b1, 1, 1'b0);
        do_frame(2, 2, 2, 2, 3, 2, 1'b1, 1'b0, 2, 1'b0);
        do_frame(1, 3, 2, 1, 3, 2, 1'b0, 1'b1, 3, 1'b0);

        for (int k = 0; k < 40; k++) begin
            int cs = $urandom % 16, ws = $urandom % 16, ac = $urandom % 16, ho = $urandom % 16;
            int w = 1 + $urandom % 6, h = $urandom % 5;
            bit te = $urandom % 2;
            bit ie = $urandom % 2;
            int inj = $urandom % 4;
            if (inj == 2 && !te) inj = 1;
            do_frame(cs, ws, ac, ho, w, h, te, ie, inj, 1'b0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule